// File: doc/BRIEF.md
# Oversampled Serial Receiver with Standby Wakeup

This block receives asynchronous serial characters on one input line. An external divider supplies a clock enable at sixteen times the bit rate. The block looks for a falling edge, confirms the start bit at mid-bit, and takes each data bit LSB first as the majority of three samples. A finished character goes into a receive data register. The block keeps five sticky status flags: data-register-full, overrun, noise, framing error and idle line. It also drives one interrupt request, formed from three of those flags, each behind its own enable.

On a bus shared by several receivers, software can put the block into standby. While in standby, incoming characters are dropped without touching the data register or the flags, and the interrupt request is held low. A select input chooses how standby ends. One setting ends it on an idle line. The other ends it on a character whose most significant bit is one (an address mark), and that character is then delivered as normal.

The pin is taken to be synchronous to `clk` already. Baud generation and transmission belong elsewhere.

Top module: `rxwake_top`

## Requirements
- R1: On a tick with `rxPin` low after a tick with it high, reception starts, and that tick is sample 1 of the start bit. If the majority at mid-bit is 1, the receiver drops the frame and goes back to looking for a falling edge.
- R2: Each bit is the majority of the pin on ticks 8, 9 and 10 of its 16-tick period. Data arrives LSB first: 8 bits when `nineBit`=0 and 9 bits when `nineBit`=1. In 8-bit mode `rxData[8]` reads 0.
- R3: On the tick that samples the stop bit at mid-bit, the character is loaded into `rxData` and `fullFlag` sets at that same clock edge.
- R4: If the three samples of any start, data or stop bit in a character disagree, `noiseFlag` sets together with `fullFlag`.
- R5: If the stop-bit majority is 0, `frameFlag` sets together with `fullFlag`.
- R6: If a character completes while `fullFlag` is 1 and `rdStrobe` is low, `ovrFlag` sets. `rxData`, `noiseFlag` and `frameFlag` keep their earlier values, and the new character is dropped.
- R7: A cycle with `rdStrobe` high clears all five flags. A flag being set in the same cycle wins over the clear.
- R8: `idleFlag` sets on the 160th consecutive tick with `rxPin` high (the 176th when `nineBit`=1), counted from the last low tick. It sets at most once for each high stretch.
- R9: `irq` = (`fullFlag`&`enFullIrq`) | (`ovrFlag`&`enOvrIrq`) | (`idleFlag`&`enIdleIrq`), and it is forced to 0 while `inStandby` is 1.
- R10: A `standbyReq` pulse sets `inStandby`. A character received in standby that does not wake the block leaves `rxData` and every flag unchanged.
- R11: With `wakeSel`=1, a character in standby whose most significant data bit is 1 clears `inStandby` and is loaded as in R3.
- R12: With `wakeSel`=0, the idle condition of R8 clears `inStandby` and does not set `idleFlag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Oversample enable, 16 per bit |
| rxPin | input | 1 | Serial input line, idles high |
| nineBit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| rdStrobe | input | 1 | Data-register read, clears the flags |
| standbyReq | input | 1 | Pulse that enters standby |
| wakeSel | input | 1 | Wake condition: 1 address mark, 0 idle line |
| enFullIrq | input | 1 | Interrupt enable for the full flag |
| enOvrIrq | input | 1 | Interrupt enable for the overrun flag |
| enIdleIrq | input | 1 | Interrupt enable for the idle flag |
| rxData | output | 9 | Received character |
| fullFlag | output | 1 | Data register holds an unread character |
| ovrFlag | output | 1 | A character was lost to overrun |
| noiseFlag | output | 1 | Sample disagreement in the held character |
| frameFlag | output | 1 | Stop bit of the held character was low |
| idleFlag | output | 1 | Idle line detected |
| inStandby | output | 1 | Standby active |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench puts a single-tick glitch on one sample of the start bit, of a data bit and of the stop bit. A receiver that trusted one sample would then corrupt the data, and one that ignored disagreement would leave the noise flag clear. It sends a short low pulse that must not start a frame, and two characters with no read between them, where a faulty design would overwrite the first or fail to flag the loss. It counts idle ticks to the exact 160th and 176th tick, which catches an off-by-one threshold or a flag that repeats. In standby it checks that a non-address character is silently dropped, that an address mark is delivered, and that an idle wake leaves the idle flag clear.

// File: rtl/rxwake_pkg.sv
package rxwake_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_START, ST_DATA, ST_STOP} rxState_t;

  // strobes from the frame control to the datapath
  typedef struct packed {
    logic capFirst;
    logic capSecond;
    logic decideStart;
    logic decideData;
    logic decideStop;
  } rxStrobe_t;
endpackage

// File: rtl/rxwake_ctrl.sv
module rxwake_ctrl
  import rxwake_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DATAW = 9
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rxPin,
  input  logic      nineBit,
  input  logic      voteBit,
  output rxStrobe_t strb
);
  localparam int CNTW  = $clog2(OSR);
  localparam int BITW  = $clog2(DATAW);
  localparam int SAMP0 = OSR / 2 - 1;

  rxState_t state;
  logic [CNTW-1:0] cnt;
  logic [BITW-1:0] bitIdx;
  logic lastPin;
  logic cntLast;
  logic [BITW-1:0] lastIdx;
  logic active;

  assign cntLast = (cnt == CNTW'(OSR - 1));
  assign lastIdx = nineBit ? BITW'(DATAW - 1) : BITW'(DATAW - 2);
  assign active  = tick && (state != ST_HUNT);

  always_comb begin
    strb             = '0;
    strb.capFirst    = active && (cnt == CNTW'(SAMP0));
    strb.capSecond   = active && (cnt == CNTW'(SAMP0 + 1));
    strb.decideStart = active && (cnt == CNTW'(SAMP0 + 2)) && (state == ST_START);
    strb.decideData  = active && (cnt == CNTW'(SAMP0 + 2)) && (state == ST_DATA);
    strb.decideStop  = active && (cnt == CNTW'(SAMP0 + 2)) && (state == ST_STOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_HUNT;
      cnt     <= '0;
      bitIdx  <= '0;
      lastPin <= 1'b1;
    end else if (tick) begin
      lastPin <= rxPin;
      if (state == ST_HUNT) begin
        if (lastPin && !rxPin) begin
          state <= ST_START;
          cnt   <= CNTW'(1);
        end
      end else begin
        cnt <= cntLast ? '0 : cnt + 1'b1;
        case (state)
          ST_START: begin
            if (strb.decideStart && voteBit) state <= ST_HUNT;
            else if (cntLast) begin
              state  <= ST_DATA;
              bitIdx <= '0;
            end
          end
          ST_DATA: begin
            if (cntLast) begin
              if (bitIdx == lastIdx) state <= ST_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end
          end
          ST_STOP: if (strb.decideStop) state <= ST_HUNT;
          default: state <= ST_HUNT;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxwake_dp.sv
module rxwake_dp
  import rxwake_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DATAW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxPin,
  input  logic             nineBit,
  input  rxStrobe_t        strb,
  input  logic             rdStrobe,
  input  logic             standbyReq,
  input  logic             wakeSel,
  output logic             voteBit,
  output logic [DATAW-1:0] rxData,
  output logic             fullFlag,
  output logic             ovrFlag,
  output logic             noiseFlag,
  output logic             frameFlag,
  output logic             idleFlag,
  output logic             inStandby
);
  localparam int ONEW = $clog2((DATAW + 2) * OSR + 1);

  logic sampA, sampB, disagree, noiseAcc;
  logic [DATAW-1:0] shreg;
  logic [DATAW-1:0] charData;
  logic [ONEW-1:0] oneCnt, idleLimit;
  logic armed, idleEvt, wakeAddr, wakeIdle, accept, loadNow, ovrEvt;

  assign voteBit  = (sampA & sampB) | (sampA & rxPin) | (sampB & rxPin);
  assign disagree = !((sampA == sampB) && (sampB == rxPin));
  assign charData = nineBit ? shreg : {1'b0, shreg[DATAW-1:1]};

  assign idleLimit = nineBit ? ONEW'((DATAW + 2) * OSR - 1) : ONEW'((DATAW + 1) * OSR - 1);
  assign idleEvt   = tick && rxPin && armed && (oneCnt == idleLimit);

  assign wakeAddr = inStandby && wakeSel && strb.decideStop && shreg[DATAW-1];
  assign wakeIdle = inStandby && !wakeSel && idleEvt;
  assign accept   = strb.decideStop && (!inStandby || wakeAddr);
  assign loadNow  = accept && (!fullFlag || rdStrobe);
  assign ovrEvt   = accept && fullFlag && !rdStrobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampA    <= 1'b1;
      sampB    <= 1'b1;
      shreg    <= '0;
      noiseAcc <= 1'b0;
    end else begin
      if (strb.capFirst)    sampA <= rxPin;
      if (strb.capSecond)   sampB <= rxPin;
      if (strb.decideData)  shreg <= {voteBit, shreg[DATAW-1:1]};
      if (strb.decideStart) noiseAcc <= disagree;
      else if (strb.decideData) noiseAcc <= noiseAcc | disagree;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oneCnt <= '0;
      armed  <= 1'b0;
    end else if (tick) begin
      if (!rxPin) begin
        oneCnt <= '0;
        armed  <= 1'b1;
      end else if (armed) begin
        if (idleEvt) begin
          armed  <= 1'b0;
          oneCnt <= '0;
        end else oneCnt <= oneCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inStandby <= 1'b0;
      rxData    <= '0;
      fullFlag  <= 1'b0;
      ovrFlag   <= 1'b0;
      noiseFlag <= 1'b0;
      frameFlag <= 1'b0;
      idleFlag  <= 1'b0;
    end else begin
      if (wakeAddr || wakeIdle) inStandby <= 1'b0;
      else if (standbyReq)      inStandby <= 1'b1;

      if (loadNow) begin
        rxData    <= charData;
        fullFlag  <= 1'b1;
        noiseFlag <= noiseAcc | disagree;
        frameFlag <= !voteBit;
      end else if (rdStrobe) begin
        fullFlag  <= 1'b0;
        noiseFlag <= 1'b0;
        frameFlag <= 1'b0;
      end

      if (ovrEvt)        ovrFlag <= 1'b1;
      else if (rdStrobe) ovrFlag <= 1'b0;

      if (idleEvt && !inStandby) idleFlag <= 1'b1;
      else if (rdStrobe)         idleFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/rxwake_top.sv
module rxwake_top
  import rxwake_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DATAW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rxPin,
  input  logic             nineBit,
  input  logic             rdStrobe,
  input  logic             standbyReq,
  input  logic             wakeSel,
  input  logic             enFullIrq,
  input  logic             enOvrIrq,
  input  logic             enIdleIrq,
  output logic [DATAW-1:0] rxData,
  output logic             fullFlag,
  output logic             ovrFlag,
  output logic             noiseFlag,
  output logic             frameFlag,
  output logic             idleFlag,
  output logic             inStandby,
  output logic             irq
);
  rxStrobe_t strb;
  logic voteBit;

  rxwake_ctrl #(.OSR(OSR), .DATAW(DATAW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxPin(rxPin),
    .nineBit(nineBit), .voteBit(voteBit), .strb(strb)
  );

  rxwake_dp #(.OSR(OSR), .DATAW(DATAW)) u_dp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxPin(rxPin),
    .nineBit(nineBit), .strb(strb), .rdStrobe(rdStrobe),
    .standbyReq(standbyReq), .wakeSel(wakeSel), .voteBit(voteBit),
    .rxData(rxData), .fullFlag(fullFlag), .ovrFlag(ovrFlag),
    .noiseFlag(noiseFlag), .frameFlag(frameFlag), .idleFlag(idleFlag),
    .inStandby(inStandby)
  );

  assign irq = !inStandby &&
               ((fullFlag && enFullIrq) || (ovrFlag && enOvrIrq) || (idleFlag && enIdleIrq));
endmodule

// File: rtl/rxwake_chk.sv
module rxwake_chk #(
  parameter int DATAW = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rdStrobe,
  input logic [DATAW-1:0] rxData,
  input logic             fullFlag,
  input logic             ovrFlag,
  input logic             noiseFlag,
  input logic             frameFlag,
  input logic             inStandby,
  input logic             irq
);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inStandby |-> !irq);

  p_noise_with_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(noiseFlag) |-> $rose(fullFlag));

  p_frame_with_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frameFlag) |-> $rose(fullFlag));

  p_ovr_keeps_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovrFlag) |-> $stable(rxData));

  p_read_clears_ovr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdStrobe |=> !ovrFlag);

  p_standby_holds_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inStandby) && inStandby) |-> $stable(rxData));
endmodule

bind rxwake_top rxwake_chk #(.DATAW(DATAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rdStrobe(rdStrobe), .rxData(rxData),
  .fullFlag(fullFlag), .ovrFlag(ovrFlag), .noiseFlag(noiseFlag),
  .frameFlag(frameFlag), .inStandby(inStandby), .irq(irq)
);

// File: tb/sim_rxwake_top.sv
module sim_rxwake_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, rxPin = 1'b1, nineBit = 1'b0, rdStrobe = 1'b0;
  logic standbyReq = 1'b0, wakeSel = 1'b0;
  logic enFullIrq = 1'b0, enOvrIrq = 1'b0, enIdleIrq = 1'b0;
  logic [8:0] rxData;
  logic fullFlag, ovrFlag, noiseFlag, frameFlag, idleFlag, inStandby, irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rxwake_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxPin(rxPin), .nineBit(nineBit),
    .rdStrobe(rdStrobe), .standbyReq(standbyReq), .wakeSel(wakeSel),
    .enFullIrq(enFullIrq), .enOvrIrq(enOvrIrq), .enIdleIrq(enIdleIrq),
    .rxData(rxData), .fullFlag(fullFlag), .ovrFlag(ovrFlag), .noiseFlag(noiseFlag),
    .frameFlag(frameFlag), .idleFlag(idleFlag), .inStandby(inStandby), .irq(irq)
  );

  // nine, sent data, stop level, glitch position (0 none, 1 start, 2+n data bit n, 11 stop),
  // expected data, expected noise, expected framing error
  typedef struct packed {
    logic       nine;
    logic [8:0] data;
    logic       stopLvl;
    logic [3:0] glitchAt;
    logic [8:0] expData;
    logic       expNoise;
    logic       expFrame;
  } vec_t;

  localparam vec_t VEC [0:6] = '{
    {1'b0, 9'h0A5, 1'b1, 4'd0,  9'h0A5, 1'b0, 1'b0},
    {1'b0, 9'h03C, 1'b1, 4'd3,  9'h03C, 1'b1, 1'b0},
    {1'b1, 9'h1C3, 1'b1, 4'd0,  9'h1C3, 1'b0, 1'b0},
    {1'b0, 9'h0FF, 1'b0, 4'd0,  9'h0FF, 1'b0, 1'b1},
    {1'b1, 9'h055, 1'b1, 4'd11, 9'h055, 1'b1, 1'b0},
    {1'b0, 9'h001, 1'b1, 4'd1,  9'h001, 1'b1, 1'b0},
    {1'b1, 9'h100, 1'b0, 4'd0,  9'h100, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic oneTick(input logic v);
    @(negedge clk);
    rxPin = v;
    tick  = 1'b1;
    @(negedge clk);
    tick  = 1'b0;
  endtask

  task automatic idleTicks(input int n);
    for (int i = 0; i < n; i++) oneTick(1'b1);
  endtask

  task automatic sendBit(input logic v, input logic glitch);
    for (int t = 0; t < 16; t++) oneTick((glitch && t == 8) ? ~v : v);
  endtask

  task automatic sendChar(input logic nine, input logic [8:0] d, input logic stopLvl,
                          input logic [3:0] glitchAt);
    nineBit = nine;
    sendBit(1'b0, glitchAt == 4'd1);
    for (int i = 0; i < (nine ? 9 : 8); i++) sendBit(d[i], glitchAt == 4'(i + 2));
    sendBit(stopLvl, glitchAt == 4'd11);
  endtask

  task automatic pulseRead();
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  task automatic pulseStandby();
    @(negedge clk);
    standbyReq = 1'b1;
    @(negedge clk);
    standbyReq = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R3 reset full", fullFlag, 0);
    check("R6 reset ovr", ovrFlag, 0);
    check("R8 reset idle", idleFlag, 0);
    check("R10 reset standby", inStandby, 0);
    check("R9 reset irq", irq, 0);
    idleTicks(4);

    // vector table: majority sampling, lengths, noise, framing
    for (int k = 0; k < 7; k++) begin
      pulseRead();
      sendChar(VEC[k].nine, VEC[k].data, VEC[k].stopLvl, VEC[k].glitchAt);
      check("R2 data", rxData, VEC[k].expData);
      check("R3 full", fullFlag, 1);
      check("R4 noise", noiseFlag, VEC[k].expNoise);
      check("R5 frame", frameFlag, VEC[k].expFrame);
      idleTicks(2);
    end

    // R7: read clears flags (full, frame from last vector)
    pulseRead();
    check("R7 full cleared", fullFlag, 0);
    check("R7 frame cleared", frameFlag, 0);

    // R1: false start
    for (int i = 0; i < 5; i++) oneTick(1'b0);
    idleTicks(30);
    check("R1 false start no char", fullFlag, 0);
    sendChar(1'b0, 9'h05A, 1'b1, 4'd0);
    check("R1 char after false start", rxData, 9'h05A);
    idleTicks(2);

    // R6: overrun keeps first character
    sendChar(1'b0, 9'h0C4, 1'b0, 4'd0);
    check("R6 ovr set", ovrFlag, 1);
    check("R6 data kept", rxData, 9'h05A);
    check("R6 frame kept", frameFlag, 0);
    // R9: gating
    enOvrIrq = 1'b1;
    @(negedge clk);
    check("R9 irq on ovr", irq, 1);
    enOvrIrq = 1'b0;
    @(negedge clk);
    check("R9 irq off", irq, 0);
    pulseRead();
    check("R7 ovr cleared", ovrFlag, 0);
    idleTicks(2);

    // R10/R11: address-mark standby
    sendChar(1'b0, 9'h033, 1'b1, 4'd0);
    enFullIrq = 1'b1;
    @(negedge clk);
    check("R9 irq on full", irq, 1);
    wakeSel = 1'b1;
    pulseStandby();
    check("R10 standby set", inStandby, 1);
    check("R9 irq masked", irq, 0);
    idleTicks(2);
    sendChar(1'b0, 9'h012, 1'b0, 4'd0);
    check("R10 data unchanged", rxData, 9'h033);
    check("R10 no overrun", ovrFlag, 0);
    check("R10 no frame", frameFlag, 0);
    check("R10 still standby", inStandby, 1);
    pulseRead();
    idleTicks(2);
    sendChar(1'b0, 9'h081, 1'b1, 4'd0);
    check("R11 woke", inStandby, 0);
    check("R11 loaded", rxData, 9'h081);
    check("R11 full", fullFlag, 1);
    check("R9 irq after wake", irq, 1);
    enFullIrq = 1'b0;
    pulseRead();
    idleTicks(2);

    // R12: idle-line wake
    wakeSel = 1'b0;
    pulseStandby();
    sendChar(1'b0, 9'h07E, 1'b1, 4'd0);
    check("R10 idle-mode drop", fullFlag, 0);
    idleTicks(143);
    check("R12 not yet", inStandby, 1);
    idleTicks(1);
    check("R12 woke", inStandby, 0);
    check("R12 no idle flag", idleFlag, 0);

    // R8: idle flag, 8-bit
    sendChar(1'b0, 9'h035, 1'b1, 4'd0);
    pulseRead();
    idleTicks(143);
    check("R8 idle at 159", idleFlag, 0);
    idleTicks(1);
    check("R8 idle at 160", idleFlag, 1);
    enIdleIrq = 1'b1;
    @(negedge clk);
    check("R9 irq on idle", irq, 1);
    enIdleIrq = 1'b0;
    pulseRead();
    check("R7 idle cleared", idleFlag, 0);
    idleTicks(200);
    check("R8 once per stretch", idleFlag, 0);

    // R8: idle flag, 9-bit
    sendChar(1'b1, 9'h035, 1'b1, 4'd0);
    pulseRead();
    idleTicks(159);
    check("R8 nine idle at 175", idleFlag, 0);
    idleTicks(1);
    check("R8 nine idle at 176", idleFlag, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule